// File: doc/BRIEF.md
# Double to Int32 Wrapping Converter

This block turns a 64-bit IEEE-754 double into a signed 32-bit integer. The fraction is always dropped toward zero. A value too large for 32 bits is not clamped: its integer part is reduced modulo 2^32, and the low 32 bits are read as two's complement. No rounding-mode or exception-control input exists, so the same operand always gives the same result.

NaN, both infinities and both zeros convert to 0. A status flag reports whether any information was lost. That happens when fractional bits are discarded or when integer bits above bit 31 fall away. The datapath has two register stages. It takes one operand per cycle, and each result appears exactly two cycles after its operand.

Top module: `f64_to_i32_wrap`

## Requirements
- R1: A NaN, +infinity or -infinity operand (exponent field bits 62..52 all ones) gives result 0 and flag 0.
- R2: A +0 or -0 operand (bits 62..0 all zero) gives result 0 and flag 0.
- R3: For finite operands with magnitude below 2^31, the result is the value truncated toward zero for both signs. For example, 2.7 gives 2 and -2.7 gives -2.
- R4: A nonzero operand of magnitude below 1.0, including subnormals (exponent field below 1023), gives result 0 and flag 1.
- R5: Large finite operands keep only the low 32 bits of the truncated magnitude. This holds for any exponent. An exponent field of 1107 or more gives 0.
- R6: A reduced magnitude of 2^31 or more is read as two's complement. For example, 2^31 gives 0x80000000 and 2^32-1 gives 0xFFFFFFFF.
- R7: A negative operand gives the two's complement negation, modulo 2^32, of its reduced magnitude. For example, -2^31 gives 0x80000000 and -(2^32+5) gives -5.
- R8: The flag (out_lossy) is 1 exactly when a fractional bit was nonzero or a nonzero integer bit above bit 31 was dropped.
- R9: out_valid equals in_valid from two clock edges earlier. Back-to-back operands produce back-to-back results.
- R10: A synchronous active-high reset clears out_valid on the next edge. It also drops any operands still in flight.
- R11: Feeding a result back in, written as a double, returns the same integer with flag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_operand | input | 64 | IEEE-754 double operand |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_result | output | 32 | Signed 32-bit result |
| out_lossy | output | 1 | Fraction discarded or high integer bits dropped |

## Verification
Directed operands cover each class of input:
- The special encodings and signed zeros show that classification takes precedence over the shift path.
- Values just inside and outside the 2^31 and 2^32 boundaries separate the wrap step from the sign reinterpretation.
- Fractions of both signs show that truncation happens before negation.
- Exponent fields of 1106 and 1107 probe the point where the last significand bit leaves the 32-bit window.

Random operands, biased toward exponents near the integer range, are then checked against a bitwise reference model every cycle. A run of reconverted results checks the round-trip property.

// File: rtl/f64_to_i32_wrap.sv
module f64_to_i32_wrap (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [63:0] in_operand,
  output logic        out_valid,
  output logic [31:0] out_result,
  output logic        out_lossy
);
  localparam logic [11:0] BIAS  = 12'd1023;
  localparam logic [11:0] POINT = 12'd1075;

  logic        sgn;
  logic [10:0] expf;
  logic [51:0] frac;
  logic        is_special, is_zero, is_sub;
  logic [52:0] sig;
  logic [63:0] wide;
  logic [11:0] e_eff, lsh, rsh;
  logic [63:0] shifted, dropmask;
  logic [31:0] mag;
  logic        lossy;

  assign sgn        = in_operand[63];
  assign expf       = in_operand[62:52];
  assign frac       = in_operand[51:0];
  assign is_special = &expf;
  assign is_sub     = (expf == 11'd0);
  assign is_zero    = is_sub && (frac == 52'd0);
  assign sig        = {~is_sub, frac};
  assign wide       = {11'd0, sig};
  assign e_eff      = is_sub ? 12'd1 : {1'b0, expf};
  assign lsh        = e_eff - POINT;
  assign rsh        = POINT - e_eff;
  assign shifted    = wide >> rsh;
  assign dropmask   = (64'd1 << rsh) - 64'd1;

  always_comb begin
    mag   = 32'd0;
    lossy = 1'b0;
    if (is_special || is_zero) begin
      mag   = 32'd0;
      lossy = 1'b0;
    end else if (e_eff < BIAS) begin
      lossy = 1'b1;
    end else if (e_eff >= POINT) begin
      lossy = 1'b1;
      if (lsh < 12'd32) mag = sig[31:0] << lsh;
    end else begin
      mag   = shifted[31:0];
      lossy = (|shifted[63:32]) || (|(wide & dropmask));
    end
  end

  logic        v1, neg1, lossy1;
  logic [31:0] mag1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1     <= 1'b0;
      neg1   <= 1'b0;
      lossy1 <= 1'b0;
      mag1   <= 32'd0;
    end else begin
      v1     <= in_valid;
      neg1   <= sgn;
      lossy1 <= lossy;
      mag1   <= mag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= 32'd0;
      out_lossy  <= 1'b0;
    end else begin
      out_valid  <= v1;
      out_result <= neg1 ? (~mag1 + 32'd1) : mag1;
      out_lossy  <= lossy1;
    end
  end
endmodule

// File: rtl/f64_to_i32_wrap_check.sv
module f64_to_i32_wrap_check (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [10:0] exp_field,
  input logic        out_valid,
  input logic [31:0] out_result,
  input logic        out_lossy
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  a_r1_special_zero: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(in_valid, 2) && (&$past(exp_field, 2)))
      |-> (out_result == 32'd0 && !out_lossy));

  a_r4_small_zero: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(in_valid, 2) && $past(exp_field, 2) < 11'd1023)
      |-> (out_result == 32'd0));

  a_r8_large_lossy: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && $past(in_valid, 2) && $past(exp_field, 2) >= 11'd1075
       && !(&$past(exp_field, 2))) |-> out_lossy);

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind f64_to_i32_wrap f64_to_i32_wrap_check u_check (
  .clk(clk), .rst(rst), .in_valid(in_valid), .exp_field(in_operand[62:52]),
  .out_valid(out_valid), .out_result(out_result), .out_lossy(out_lossy));

// File: tb/test_f64_to_i32_wrap.sv
module test_f64_to_i32_wrap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = 64'd0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_lossy;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  f64_to_i32_wrap i_f64_to_i32_wrap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .out_valid(out_valid), .out_result(out_result), .out_lossy(out_lossy));

  logic        h_v [2];
  logic [32:0] h_x [2];
  string       h_tag [2];

  function automatic logic [32:0] ref_conv(input logic [63:0] b);
    int          e;
    int          p;
    logic [52:0] s;
    logic [31:0] acc;
    bit          lost;
    e    = int'(b[62:52]);
    acc  = 32'd0;
    lost = 1'b0;
    if (e == 2047 || b[62:0] == 63'd0) return 33'd0;
    s = {(e != 0), b[51:0]};
    if (e == 0) e = 1;
    for (int i = 0; i < 53; i++) begin
      if (s[i]) begin
        p = i + e - 1075;
        if (p < 0 || p > 31) lost = 1'b1;
        else acc[p] = 1'b1;
      end
    end
    if (b[63]) acc = -acc;
    return {lost, acc};
  endfunction

  task automatic step(input bit r, input bit v, input logic [63:0] op, input string tag);
    @(negedge clk);
    total++;
    if (out_valid !== h_v[1]) begin
      bad++;
      $display("FAIL %s: out_valid got %0b expected %0b", h_tag[1], out_valid, h_v[1]);
    end
    if (h_v[1]) begin
      total++;
      if ({out_lossy, out_result} !== h_x[1]) begin
        bad++;
        $display("FAIL %s: got lossy=%0b result=%h expected lossy=%0b result=%h",
                 h_tag[1], out_lossy, out_result, h_x[1][32], h_x[1][31:0]);
      end
    end
    rst = r; in_valid = v; in_operand = op;
    if (r) begin
      for (int k = 0; k < 2; k++) begin h_v[k] = 1'b0; h_x[k] = 33'd0; h_tag[k] = "R10"; end
    end else begin
      h_v[1] = h_v[0]; h_x[1] = h_x[0]; h_tag[1] = h_tag[0];
      h_v[0] = v; h_x[0] = ref_conv(op); h_tag[0] = tag;
    end
  endtask

  task automatic put(input logic [63:0] op, input string tag);
    step(1'b0, 1'b1, op, tag);
  endtask

  function automatic logic [63:0] dbl(input real x);
    return $realtobits(x);
  endfunction

  initial begin
    for (int k = 0; k < 2; k++) begin h_v[k] = 1'b0; h_x[k] = 33'd0; h_tag[k] = "R10"; end
    step(1'b1, 1'b0, 64'd0, "R10");
    step(1'b1, 1'b1, 64'd0, "R10");
    step(1'b0, 1'b0, 64'd0, "R10");
    // R1
    put(64'h7FF8_0000_0000_0000, "R1");
    put(64'hFFF0_0000_0000_0000, "R1");
    put(64'h7FF0_0000_0000_0000, "R1");
    put(64'h7FF0_0000_0000_0001, "R1");
    // R2
    put(64'h0000_0000_0000_0000, "R2");
    put(64'h8000_0000_0000_0000, "R2");
    // R3
    put(dbl(2.7), "R3");
    put(dbl(-2.7), "R3");
    put(dbl(2147483647.9), "R3");
    put(dbl(-2147483647.5), "R3");
    put(dbl(1.0), "R3");
    // R4
    put(dbl(0.5), "R4");
    put(dbl(-0.999), "R4");
    put(64'h0000_0000_0000_0001, "R4");
    put(64'h800F_FFFF_FFFF_FFFF, "R4");
    // R5
    put(dbl(4294967296.0 + 7.0), "R5");
    put(dbl(1.0e20), "R5");
    put({1'b0, 11'd1106, 52'h0_0000_0000_0001}, "R5");
    put({1'b0, 11'd1107, 52'hF_FFFF_FFFF_FFFF}, "R5");
    put({1'b0, 11'd2046, 52'h1_2345_6789_ABCD}, "R5");
    // R6
    put(dbl(2147483648.0), "R6");
    put(dbl(4294967295.0), "R6");
    // R7
    put(dbl(-2147483648.0), "R7");
    put(dbl(-4294967301.0), "R7");
    put(dbl(-1.0e15), "R7");
    // R8
    put(dbl(3.0), "R8");
    put(dbl(3.25), "R8");
    put(dbl(8589934592.0), "R8");
    // R9: idle gaps between operands
    step(1'b0, 1'b0, dbl(9.0), "R9");
    put(dbl(-17.0), "R9");
    step(1'b0, 1'b0, 64'd0, "R9");
    // R10: reset with operands in flight
    put(dbl(11.0), "R10");
    step(1'b1, 1'b1, dbl(12.0), "R10");
    step(1'b0, 1'b0, 64'd0, "R10");
    step(1'b0, 1'b0, 64'd0, "R10");
    // random sweep
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] op;
      op = {$urandom, $urandom};
      if (n % 2 == 0) op[62:52] = 11'(1000 + ($urandom % 120));
      if (n % 5 == 0) step(1'b0, 1'b0, op, "R9");
      else put(op, "R9");
    end
    // R11
    for (int n = 0; n < 200; n++) begin
      logic [63:0] op;
      logic [32:0] first;
      op = {$urandom, $urandom};
      op[62:52] = 11'(1020 + ($urandom % 100));
      first = ref_conv(op);
      put(op, "R11");
      put($realtobits($itor($signed(first[31:0]))), "R11");
    end
    step(1'b0, 1'b0, 64'd0, "R9");
    step(1'b0, 1'b0, 64'd0, "R9");
    step(1'b0, 1'b0, 64'd0, "R9");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got no end of run expected end within 100000 cycles");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule